// File: doc/BRIEF.md
# Fuse-Locked Dual Wiper Setting Controller

This block holds the digital codes for a set of potentiometer wipers and manages their one-time fuse programming. A serial front end hands it decoded write commands: a channel number, a data byte and three flag bits. The flags are shutdown, program and overwrite. The block returns the effective wiper code for every channel, a shutdown flag per channel, a programming request with a fixed-length pulse window, and a two-bit validation status.

After reset the wipers start from one of two places. With the fuses blank they start at midscale. With the fuses already programmed they start at the codes read back from the fuse store. Before programming, software may move the wipers freely. One program command captures all channel codes and asks the fuse store to burn them. The result returned at the end of the window either locks the setting or records a permanent error. Once the setting is locked, an overwrite mode can still drive a channel to a temporary code. Clearing the mode returns the channel to its locked code.

The fuse array itself sits outside the block and is seen here only as signals: a programmed flag, the stored codes and a pass/fail result. A command is taken on any clock edge where `cmd_valid` is high and the block is not busy. Its effect is visible at the outputs after that edge.

Top module: `otp_wiper_ctrl`

## Requirements
- R1: While reset is held with `fuse_burnt` low, every channel loads midscale (1 << (W-1), 0x80 for W=8), and the outputs show status 2'b00 ("ready"), `busy_o` low and all shutdown flags clear.
- R2: While reset is held with `fuse_burnt` high, channel i loads `fuse_codes[i*W +: W]` and the status reads 2'b11 ("locked"); any overwrite that was active before reset is gone.
- R3: In status 2'b00 or 2'b10, an accepted command with `cmd_chan` = i stores `cmd_data` into channel i only. Channel 0 appears on `wiper_o[W-1:0]`. There is no limit on how many such writes are made.
- R4: An accepted command with `cmd_prog` = 1 while the status is 2'b00 stores its data and then raises `busy_o` and `blow_req_o` for exactly BLOW_CYCLES clock cycles. During the window `burn_codes_o` carries every channel's stored code. In any other status the program bit is ignored and no window starts.
- R5: While `busy_o` is high, every command is ignored: no wiper code, stored code or shutdown flag changes.
- R6: On the last cycle of the window the block samples `blow_ok`. A high value sets the status to 2'b11 and a low value sets it to 2'b10 (error). The status stays 2'b00 during the window.
- R7: In status 2'b11 the stored codes never change. A command with `cmd_ovr` = 0 leaves the channel showing its locked code. A command with `cmd_ovr` = 1 makes the channel show `cmd_data`.
- R8: In status 2'b11, a command with `cmd_ovr` = 0 ends a channel's overwrite, and the channel's output returns to its locked code.
- R9: Every accepted command sets the selected channel's shutdown flag to `cmd_sd`. While the flag is set the channel's `wiper_o` field reads 0 (wiper tied to B), yet its data is still stored and is visible on `burn_codes_o`. Clearing the flag shows the latest stored code.
- R10: Status 2'b10 and status 2'b11 hold until reset. In status 2'b10, writes behave as in R3 and no new programming can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; presets load while low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_chan | input | CH_W | Target channel index |
| cmd_sd | input | 1 | Shutdown request for the target channel |
| cmd_prog | input | 1 | Program (fuse burn) request |
| cmd_ovr | input | 1 | Overwrite request, used once locked |
| cmd_data | input | W | Wiper code |
| fuse_burnt | input | 1 | Fuse store reports it is programmed |
| fuse_codes | input | NCH*W | Codes read from the fuse store, channel 0 lowest |
| blow_ok | input | 1 | Burn result, sampled on the last window cycle |
| wiper_o | output | NCH*W | Effective wiper codes, channel 0 lowest |
| shut_o | output | NCH | Per-channel shutdown flags |
| blow_req_o | output | 1 | Fuse burn request, high for the whole window |
| burn_codes_o | output | NCH*W | Stored codes to be burned |
| busy_o | output | 1 | Burn window in progress |
| vstat_o | output | 2 | Validation status: 00 ready, 10 error, 11 locked |

## Verification
A corrupted status register shows up at once. On the next accepted write, a locked part starts following data it should refuse, or a blank part refuses it; either is visible on `wiper_o` in the cycle after the command. A window counter that is off by one shows as a wrong `busy_o` length, and a wrong sampling moment shows as the wrong final status. A stored code lost during shutdown or overwrite is caught through `burn_codes_o` while the condition is still active, and through `wiper_o` as soon as the condition ends.

// File: rtl/otpw_pkg.sv
package otpw_pkg;

   // validation status; the two-bit codes are read by software and must not move
   typedef enum logic [1:0] {
      VS_READY = 2'b00,
      VS_FAIL  = 2'b10,
      VS_DONE  = 2'b11
   } vstat_e;

   // flag bits carried by one decoded command
   typedef struct packed {
      logic sd;
      logic prog;
      logic ovr;
   } cmd_flags_t;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/otpw_sequencer.sv
module otpw_sequencer
   import otpw_pkg::*;
#(
   parameter int BLOW_CYCLES = 80_000_000,
   parameter int CNT_W       = $clog2(BLOW_CYCLES + 1)
)(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   fuse_burnt,
   input  logic   start_i,
   input  logic   blow_ok,
   output logic   busy_o,
   output vstat_e vstat_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOW_CYCLES - 1);

   vstat_e           status_q;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= fuse_burnt ? VS_DONE : VS_READY;
         busy_q   <= 1'b0;
         cnt_q    <= '0;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q   <= 1'b0;
            status_q <= blow_ok ? VS_DONE : VS_FAIL;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end else if (start_i && status_q == VS_READY) begin
         busy_q <= 1'b1;
         cnt_q  <= LAST;
      end
   end

   assign busy_o  = busy_q;
   assign vstat_o = status_q;

   // R6
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> status_q == VS_READY);

   // R10
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_q == VS_FAIL |=> status_q == VS_FAIL);

   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_q == VS_DONE |=> status_q == VS_DONE);

   // R4
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q != VS_READY) |=> !busy_q);

endmodule

// File: rtl/otpw_channel.sv
module otpw_channel #(
   parameter int W          = 8,
   parameter bit ZERO_IN_SD = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] preset_i,
   input  logic         wr_i,
   input  logic         sd_i,
   input  logic         ow_i,
   input  logic [W-1:0] data_i,
   input  logic         locked_i,
   output logic [W-1:0] code_o,
   output logic         shut_o,
   output logic [W-1:0] base_o
);

   logic [W-1:0] base_q;
   logic [W-1:0] ovr_q;
   logic         ovr_on_q;
   logic         shut_q;
   logic [W-1:0] eff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= preset_i;
         ovr_q    <= '0;
         ovr_on_q <= 1'b0;
         shut_q   <= 1'b0;
      end else if (wr_i) begin
         shut_q <= sd_i;
         if (locked_i) begin
            ovr_on_q <= ow_i;
            if (ow_i) ovr_q <= data_i;
         end else begin
            base_q <= data_i;
         end
      end
   end

   assign eff = ovr_on_q ? ovr_q : base_q;

   generate
      if (ZERO_IN_SD) begin : g_sd_zero
         assign code_o = shut_q ? '0 : eff;
      end else begin : g_sd_flag
         assign code_o = eff;
      end
   endgenerate

   assign shut_o = shut_q;
   assign base_o = base_q;

   // R7
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_i |=> $stable(base_q));

   // R8
   ovr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_i && wr_i && !ow_i && !sd_i) |=> code_o == base_q);

endmodule

// File: rtl/otp_wiper_ctrl.sv
module otp_wiper_ctrl
   import otpw_pkg::*;
#(
   parameter int W           = 8,
   parameter int NCH         = 2,
   parameter int BLOW_CYCLES = 80_000_000,
   parameter bit ZERO_IN_SD  = 1'b1,
   parameter int CH_W        = sel_width(NCH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CH_W-1:0]  cmd_chan,
   input  logic             cmd_sd,
   input  logic             cmd_prog,
   input  logic             cmd_ovr,
   input  logic [W-1:0]     cmd_data,
   input  logic             fuse_burnt,
   input  logic [NCH*W-1:0] fuse_codes,
   input  logic             blow_ok,
   output logic [NCH*W-1:0] wiper_o,
   output logic [NCH-1:0]   shut_o,
   output logic             blow_req_o,
   output logic [NCH*W-1:0] burn_codes_o,
   output logic             busy_o,
   output logic [1:0]       vstat_o
);

   localparam logic [W-1:0] MIDSCALE = W'(1) << (W - 1);

   generate
      if (W < 2)           begin : g_bad_w   $error("W must be at least 2");          end
      if (NCH < 1)         begin : g_bad_n   $error("NCH must be at least 1");        end
      if (BLOW_CYCLES < 1) begin : g_bad_b   $error("BLOW_CYCLES must be positive");  end
   endgenerate

   cmd_flags_t flags;
   vstat_e     vstat;
   logic       busy;
   logic       accept;
   logic       locked;
   logic       start;

   assign flags  = '{sd: cmd_sd, prog: cmd_prog, ovr: cmd_ovr};
   assign accept = cmd_valid && !busy;
   assign locked = (vstat == VS_DONE);
   assign start  = accept && flags.prog && (vstat == VS_READY);

   otpw_sequencer #(
      .BLOW_CYCLES (BLOW_CYCLES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fuse_burnt (fuse_burnt),
      .start_i    (start),
      .blow_ok    (blow_ok),
      .busy_o     (busy),
      .vstat_o    (vstat)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic [W-1:0] preset;
         logic         wr;
         assign preset = fuse_burnt ? fuse_codes[i*W +: W] : MIDSCALE;
         assign wr     = accept && (cmd_chan == CH_W'(i));

         otpw_channel #(
            .W          (W),
            .ZERO_IN_SD (ZERO_IN_SD)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .preset_i (preset),
            .wr_i     (wr),
            .sd_i     (flags.sd),
            .ow_i     (flags.ovr),
            .data_i   (cmd_data),
            .locked_i (locked),
            .code_o   (wiper_o[i*W +: W]),
            .shut_o   (shut_o[i]),
            .base_o   (burn_codes_o[i*W +: W])
         );
      end
   endgenerate

   assign busy_o     = busy;
   assign blow_req_o = busy;
   assign vstat_o    = vstat;

   // R5
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(burn_codes_o) && $stable(shut_o));

   // R5
   busy_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(wiper_o));

endmodule

// File: tb/test_otp_wiper_ctrl.sv
`timescale 1ns/1ps
module test_otp_wiper_ctrl;

   localparam int W     = 8;
   localparam int NCH   = 2;
   localparam int BLOW  = 20;
   localparam int CH_W  = 1;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cmd_valid;
   logic [CH_W-1:0]  cmd_chan;
   logic             cmd_sd, cmd_prog, cmd_ovr;
   logic [W-1:0]     cmd_data;
   logic             fuse_burnt;
   logic [NCH*W-1:0] fuse_codes;
   logic             blow_ok;
   logic [NCH*W-1:0] wiper_o;
   logic [NCH-1:0]   shut_o;
   logic             blow_req_o;
   logic [NCH*W-1:0] burn_codes_o;
   logic             busy_o;
   logic [1:0]       vstat_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   otp_wiper_ctrl #(
      .W (W), .NCH (NCH), .BLOW_CYCLES (BLOW), .ZERO_IN_SD (1'b1)
   ) i_otp_wiper_ctrl (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_chan (cmd_chan),
      .cmd_sd (cmd_sd), .cmd_prog (cmd_prog), .cmd_ovr (cmd_ovr), .cmd_data (cmd_data),
      .fuse_burnt (fuse_burnt), .fuse_codes (fuse_codes), .blow_ok (blow_ok),
      .wiper_o (wiper_o), .shut_o (shut_o), .blow_req_o (blow_req_o),
      .burn_codes_o (burn_codes_o), .busy_o (busy_o), .vstat_o (vstat_o)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic burnt, input logic [NCH*W-1:0] codes);
      @(negedge clk);
      rst_n = 1'b0; fuse_burnt = burnt; fuse_codes = codes;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input int ch, input logic sd, input logic t, input logic ow, input logic [W-1:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_chan = CH_W'(ch); cmd_sd = sd; cmd_prog = t; cmd_ovr = ow; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_prog = 1'b0; cmd_ovr = 1'b0; cmd_sd = 1'b0;
   endtask

   task automatic t_reset_blank();
      do_reset(1'b0, 16'h0000);
      chk("R1", "wipers", wiper_o, 16'h8080);
      chk("R1", "status", vstat_o, 2'b00);
      chk("R1", "busy",   busy_o, 1'b0);
      chk("R1", "shut",   shut_o, 2'b00);
   endtask

   task automatic t_free_writes();
      send(0, 0, 0, 0, 8'h12); chk("R3", "ch0 write", wiper_o, 16'h8012);
      send(1, 0, 0, 0, 8'hEE); chk("R3", "ch1 write", wiper_o, 16'hEE12);
      send(0, 0, 0, 0, 8'h34); chk("R3", "ch0 rewrite", wiper_o, 16'hEE34);
      send(0, 0, 0, 1, 8'h35); chk("R3", "ovr ignored when blank", wiper_o, 16'hEE35);
   endtask

   task automatic t_shutdown();
      send(1, 1, 0, 0, 8'h55);
      chk("R9", "shut wiper zero", wiper_o, 16'h0035);
      chk("R9", "shut flag", shut_o, 2'b10);
      send(1, 1, 0, 0, 8'h66);
      chk("R9", "stored in shutdown", burn_codes_o, 16'h6635);
      send(0, 0, 0, 0, 8'h36);
      chk("R9", "other channel live", wiper_o, 16'h0036);
      send(1, 0, 0, 0, 8'h66);
      chk("R9", "leave shutdown", wiper_o, 16'h6636);
      chk("R9", "flags clear", shut_o, 2'b00);
   endtask

   task automatic t_program_ok();
      int n;
      blow_ok = 1'b1;
      send(0, 0, 1, 0, 8'hA5);
      chk("R4", "busy", busy_o, 1'b1);
      chk("R4", "blow_req", blow_req_o, 1'b1);
      chk("R4", "burn codes", burn_codes_o, 16'h66A5);
      chk("R6", "status during window", vstat_o, 2'b00);
      n = 1;
      while (busy_o && n < 1000) begin
         @(negedge clk);
         if (busy_o) n++;
      end
      chk("R4", "window length", n, BLOW);
      chk("R6", "status locked", vstat_o, 2'b11);
      chk("R6", "busy low", busy_o, 1'b0);
   endtask

   task automatic t_locked();
      send(0, 0, 0, 0, 8'h10); chk("R7", "locked write ignored", wiper_o, 16'h66A5);
      send(0, 0, 1, 0, 8'h22);
      chk("R4", "second program no busy", busy_o, 1'b0);
      chk("R4", "second program no change", wiper_o, 16'h66A5);
      send(0, 0, 0, 1, 8'h10); chk("R7", "overwrite ch0", wiper_o, 16'h6610);
      send(1, 0, 0, 1, 8'h77); chk("R7", "overwrite ch1", wiper_o, 16'h7710);
      chk("R7", "stored frozen", burn_codes_o, 16'h66A5);
      send(0, 0, 0, 0, 8'h99); chk("R8", "ow clear reverts", wiper_o, 16'h77A5);
      chk("R10", "still locked", vstat_o, 2'b11);
   endtask

   task automatic t_reset_burnt();
      do_reset(1'b1, 16'h3CC3);
      chk("R2", "fuse presets", wiper_o, 16'h3CC3);
      chk("R2", "status locked", vstat_o, 2'b11);
      send(0, 0, 0, 0, 8'h01);
      chk("R2", "no overwrite after reset", wiper_o, 16'h3CC3);
   endtask

   task automatic t_program_fail();
      int n;
      do_reset(1'b0, 16'h0000);
      blow_ok = 1'b0;
      send(1, 0, 1, 0, 8'h40);
      chk("R4", "busy on fail path", busy_o, 1'b1);
      send(0, 1, 0, 0, 8'h11);
      chk("R5", "wiper held while busy", wiper_o, 16'h4080);
      chk("R5", "stored held while busy", burn_codes_o, 16'h4080);
      chk("R5", "shut held while busy", shut_o, 2'b00);
      n = 0;
      while (busy_o && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk("R6", "status error", vstat_o, 2'b10);
      send(0, 0, 1, 0, 8'h22);
      chk("R10", "no program after error", busy_o, 1'b0);
      chk("R10", "error sticky", vstat_o, 2'b10);
      chk("R10", "write after error", wiper_o, 16'h4022);
      send(0, 0, 0, 0, 8'h23);
      chk("R3", "write in error state", wiper_o, 16'h4023);
   endtask

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_chan = '0; cmd_sd = 1'b0; cmd_prog = 1'b0;
      cmd_ovr = 1'b0; cmd_data = '0; fuse_burnt = 1'b0; fuse_codes = '0; blow_ok = 1'b0;
      t_reset_blank();
      t_free_writes();
      t_shutdown();
      t_program_ok();
      t_locked();
      t_reset_burnt();
      t_program_fail();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule